// File: doc/BRIEF.md
# Paired ALU and Load/Store Integer Pipeline

This block is a four-stage in-order integer pipeline. A register-type instruction word holds two operations that run together: a register-to-register ALU operation and a word load or store. The load or store uses a register value as its address, with no offset added. The stages are fetch, decode with operand read, a merged ALU-and-memory stage, and write-back. Write-back can update two registers per instruction: the ALU destination and, for a load, the transfer-data register.

Instruction memory and data memory attach through simple combinational read ports. The pipeline fetches one word per cycle and never stalls. Each operand is read from the newest available value, either the register file or an older instruction still in the pipe. Conditional branches and the jump are resolved at decode. A taken transfer discards the single instruction fetched behind it. There is no delay slot.

Top module: `lsp_core`

## Requirements
- R1: While reset is asserted, the instruction address is 0 and no data-memory read or write is requested. The first instruction fetched after reset comes from address 0.
- R2: Register-type words are laid out, MSB to LSB, as op[31:26], src1[25:21], src2[20:16], dst[15:11], dir[10], addr_reg[9:5], data_reg[4:0]. The ALU opcodes are 0x01 add, 0x02 subtract (src1-src2), 0x03 and, 0x04 or, 0x05 xor and 0x06 signed set-less-than. The ALU result is written to dst.
- R3: Immediate-type words are laid out as op[31:26], src1[25:21], dst[20:16], imm[15:0]. Opcode 0x10 adds the sign-extended imm to src1. Opcode 0x11 shifts src1 left by imm[4:0].
- R4: In a register-type word with dir=0, the word at the address held in addr_reg is loaded into data_reg. No displacement is added to the address.
- R5: In a register-type word with dir=1, the value of data_reg is stored to the address held in addr_reg.
- R6: When addr_reg and data_reg are both register 0, no data-memory access takes place, for either value of dir.
- R7: Register 0 always reads as zero. Writes to register 0 from either write-back path are discarded.
- R8: When dst and data_reg name the same register in a load word, the register receives the loaded word.
- R9: Every instruction sees the results of all older instructions, including an immediately preceding load, without any stall. One instruction issues per cycle.
- R10: Opcode 0x18 branches when src1 equals zero, and opcode 0x19 branches when src1 is nonzero. The target is the branch's own address plus the sign-extended imm in bytes. Opcode 0x1A always jumps to its own address plus the sign-extended 26-bit field.
- R11: A taken branch or jump discards exactly the one instruction fetched after it. There is no delay slot.
- R12: Any opcode not listed in R2, R3 or R10 changes no register, makes no memory access and does not redirect fetch.
- R13: When no transfer is taken, fetch advances by 4 bytes every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Byte address of the instruction being fetched |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Byte address for the companion memory operation |
| dmem_re_o | output | 1 | Load request |
| dmem_we_o | output | 1 | Store request |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o, same cycle |

## Verification
An instruction in issue slot t is fetched in cycle t. It is decoded in t+1, and its store or load appears on the data port in cycle t+2, counted in rising edges after reset release. A taken transfer adds one slot for the discarded word. Register results become visible two cycles later, when a store in the dump sequence writes them out. The bench's reference model assigns each expected store its address, its data and that cycle number. Each store on the port is checked against all three, and the numbers of stores and loads are compared at the end of every program.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam logic [5:0] OP_ADD  = 6'h01;
  localparam logic [5:0] OP_SUB  = 6'h02;
  localparam logic [5:0] OP_AND  = 6'h03;
  localparam logic [5:0] OP_OR   = 6'h04;
  localparam logic [5:0] OP_XOR  = 6'h05;
  localparam logic [5:0] OP_SLT  = 6'h06;
  localparam logic [5:0] OP_ADDI = 6'h10;
  localparam logic [5:0] OP_SLLI = 6'h11;
  localparam logic [5:0] OP_BEQZ = 6'h18;
  localparam logic [5:0] OP_BNEZ = 6'h19;
  localparam logic [5:0] OP_JMP  = 6'h1A;

  localparam int RAW = 5;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLL
  } alu_op_e;

  typedef enum logic [1:0] {BR_NONE, BR_EQZ, BR_NEZ, BR_JMP} br_e;

  typedef struct packed {
    logic           rd_we;
    logic [RAW-1:0] rs1;
    logic [RAW-1:0] rs2;
    logic [RAW-1:0] rd;
    logic [RAW-1:0] ta;
    logic [RAW-1:0] td;
    logic           mem_en;
    logic           mem_st;
    logic           use_imm;
    alu_op_e        alu_op;
    br_e            br;
    logic [31:0]    imm;
  } dec_t;
endpackage

// File: rtl/lsp_decode.sv
module lsp_decode
  import lsp_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        valid_i,
  output dec_t        dec_o
);
  logic [5:0] op;
  assign op = instr_i[31:26];

  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      unique case (op)
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SLT: begin
          dec_o.rs1    = instr_i[25:21];
          dec_o.rs2    = instr_i[20:16];
          dec_o.rd     = instr_i[15:11];
          dec_o.rd_we  = instr_i[15:11] != '0;
          dec_o.mem_st = instr_i[10];
          dec_o.ta     = instr_i[9:5];
          dec_o.td     = instr_i[4:0];
          // both transfer fields zero: no memory operation
          dec_o.mem_en = (instr_i[9:5] != '0) || (instr_i[4:0] != '0);
          case (op)
            OP_SUB:  dec_o.alu_op = ALU_SUB;
            OP_AND:  dec_o.alu_op = ALU_AND;
            OP_OR:   dec_o.alu_op = ALU_OR;
            OP_XOR:  dec_o.alu_op = ALU_XOR;
            OP_SLT:  dec_o.alu_op = ALU_SLT;
            default: dec_o.alu_op = ALU_ADD;
          endcase
        end
        OP_ADDI, OP_SLLI: begin
          dec_o.rs1     = instr_i[25:21];
          dec_o.rd      = instr_i[20:16];
          dec_o.rd_we   = instr_i[20:16] != '0;
          dec_o.use_imm = 1'b1;
          dec_o.imm     = {{16{instr_i[15]}}, instr_i[15:0]};
          dec_o.alu_op  = (op == OP_SLLI) ? ALU_SLL : ALU_ADD;
        end
        OP_BEQZ, OP_BNEZ: begin
          dec_o.rs1 = instr_i[25:21];
          dec_o.imm = {{16{instr_i[15]}}, instr_i[15:0]};
          dec_o.br  = (op == OP_BEQZ) ? BR_EQZ : BR_NEZ;
        end
        OP_JMP: begin
          dec_o.imm = {{6{instr_i[25]}}, instr_i[25:0]};
          dec_o.br  = BR_JMP;
        end
        default: dec_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsp_alu.sv
module lsp_alu
  import lsp_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int SW = $clog2(W);

  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLT: y_o = W'($signed(a_i) < $signed(b_i));
      ALU_SLL: y_o = a_i << b_i[SW-1:0];
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/lsp_regfile.sv
module lsp_regfile #(
  parameter int W   = 32,
  parameter int N   = 32,
  parameter int NRD = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NRD-1:0][$clog2(N)-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]         rdata_o,
  input  logic                          wa_en_i,
  input  logic [$clog2(N)-1:0]          wa_addr_i,
  input  logic [W-1:0]                  wa_data_i,
  input  logic                          wl_en_i,
  input  logic [$clog2(N)-1:0]          wl_addr_i,
  input  logic [W-1:0]                  wl_data_i
);
  localparam int AW = $clog2(N);

  logic [W-1:0] mem_q [N];

  // load port written last: wins when both target the same entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else begin
      if (wa_en_i && wa_addr_i != '0) mem_q[wa_addr_i] <= wa_data_i;
      if (wl_en_i && wl_addr_i != '0) mem_q[wl_addr_i] <= wl_data_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_comb begin
      if (raddr_i[g] == AW'(0))                        rdata_o[g] = '0;
      else if (wl_en_i && wl_addr_i == raddr_i[g])     rdata_o[g] = wl_data_i;
      else if (wa_en_i && wa_addr_i == raddr_i[g])     rdata_o[g] = wa_data_i;
      else                                             rdata_o[g] = mem_q[raddr_i[g]];
    end
  end
endmodule

// File: rtl/lsp_core.sv
module lsp_core
  import lsp_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic            dmem_re_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int NOPS = 4;
  localparam int AW   = $clog2(NREG);

  // fetch / decode registers
  logic [XLEN-1:0] pc_q, pc_d, ipc_q;
  logic [31:0]     ir_q;
  logic            iv_q;

  // decode
  dec_t dec;
  lsp_decode u_dec (.instr_i(ir_q), .valid_i(iv_q), .dec_o(dec));

  logic [NOPS-1:0][AW-1:0]   rf_raddr;
  logic [NOPS-1:0][XLEN-1:0] rf_rdata;
  logic [NOPS-1:0][XLEN-1:0] opv;

  assign rf_raddr[0] = AW'(dec.rs1);
  assign rf_raddr[1] = AW'(dec.rs2);
  assign rf_raddr[2] = AW'(dec.ta);
  assign rf_raddr[3] = AW'(dec.td);

  // combined stage registers
  alu_op_e         ex_alu_op;
  logic            ex_rd_we, ex_mem_en, ex_mem_st;
  logic [RAW-1:0]  ex_rd, ex_td;
  logic [XLEN-1:0] ex_a, ex_b, ex_ta_v, ex_td_v, alu_y;
  logic            mex_alu_we, mex_ld_we;

  // write-back registers
  logic            wa_en_q, wl_en_q;
  logic [AW-1:0]   wa_addr_q, wl_addr_q;
  logic [XLEN-1:0] wa_data_q, wl_data_q;

  lsp_regfile #(.W(XLEN), .N(NREG), .NRD(NOPS)) u_rf (
    .clk_i, .rst_ni,
    .raddr_i  (rf_raddr),
    .rdata_o  (rf_rdata),
    .wa_en_i  (wa_en_q),
    .wa_addr_i(wa_addr_q),
    .wa_data_i(wa_data_q),
    .wl_en_i  (wl_en_q),
    .wl_addr_i(wl_addr_q),
    .wl_data_i(wl_data_q)
  );

  assign mex_alu_we = ex_rd_we;
  assign mex_ld_we  = ex_mem_en && !ex_mem_st && (ex_td != '0);

  // operand selection: combined stage is newest, register file bypasses write-back
  for (genvar g = 0; g < NOPS; g++) begin : g_fwd
    always_comb begin
      if (rf_raddr[g] == '0)                                   opv[g] = '0;
      else if (mex_ld_we && AW'(ex_td) == rf_raddr[g])         opv[g] = dmem_rdata_i;
      else if (mex_alu_we && AW'(ex_rd) == rf_raddr[g])        opv[g] = alu_y;
      else                                                     opv[g] = rf_rdata[g];
    end
  end

  // branch resolution in decode
  logic            br_taken;
  logic [XLEN-1:0] br_target;

  always_comb begin
    unique case (dec.br)
      BR_EQZ:  br_taken = (opv[0] == '0);
      BR_NEZ:  br_taken = (opv[0] != '0);
      BR_JMP:  br_taken = 1'b1;
      default: br_taken = 1'b0;
    endcase
    br_target = ipc_q + XLEN'(dec.imm);
    pc_d      = br_taken ? br_target : pc_q + XLEN'(4);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= XLEN'(RESET_PC);
      ipc_q <= '0;
      ir_q  <= '0;
      iv_q  <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      ipc_q <= pc_q;
      ir_q  <= imem_data_i;
      iv_q  <= !br_taken;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_alu_op <= ALU_ADD;
      ex_rd_we  <= 1'b0;
      ex_mem_en <= 1'b0;
      ex_mem_st <= 1'b0;
      ex_rd     <= '0;
      ex_td     <= '0;
      ex_a      <= '0;
      ex_b      <= '0;
      ex_ta_v   <= '0;
      ex_td_v   <= '0;
    end else begin
      ex_alu_op <= dec.alu_op;
      ex_rd_we  <= dec.rd_we;
      ex_mem_en <= dec.mem_en;
      ex_mem_st <= dec.mem_st;
      ex_rd     <= dec.rd;
      ex_td     <= dec.td;
      ex_a      <= opv[0];
      ex_b      <= dec.use_imm ? dec.imm[XLEN-1:0] : opv[1];
      ex_ta_v   <= opv[2];
      ex_td_v   <= opv[3];
    end
  end

  lsp_alu #(.W(XLEN)) u_alu (.op_i(ex_alu_op), .a_i(ex_a), .b_i(ex_b), .y_o(alu_y));

  assign dmem_addr_o  = ex_ta_v;
  assign dmem_wdata_o = ex_td_v;
  assign dmem_we_o    = ex_mem_en && ex_mem_st;
  assign dmem_re_o    = ex_mem_en && !ex_mem_st;
  assign imem_addr_o  = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_en_q   <= 1'b0;
      wl_en_q   <= 1'b0;
      wa_addr_q <= '0;
      wl_addr_q <= '0;
      wa_data_q <= '0;
      wl_data_q <= '0;
    end else begin
      wa_en_q   <= mex_alu_we;
      wa_addr_q <= AW'(ex_rd);
      wa_data_q <= alu_y;
      wl_en_q   <= mex_ld_we;
      wl_addr_q <= AW'(ex_td);
      wl_data_q <= dmem_rdata_i;
    end
  end
endmodule

// File: rtl/lsp_core_chk.sv
module lsp_core_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] imem_addr_o,
  input logic            br_taken,
  input logic [XLEN-1:0] br_target,
  input logic            iv_q,
  input logic            dmem_re_o,
  input logic            dmem_we_o,
  input logic [XLEN-1:0] dmem_rdata_i,
  input logic            mex_ld_we,
  input logic            wa_en_q,
  input logic [AW-1:0]   wa_addr_q,
  input logic            wl_en_q,
  input logic [AW-1:0]   wl_addr_q,
  input logic [XLEN-1:0] wl_data_q
);
  assert_pc_step_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_taken |=> imem_addr_o == $past(imem_addr_o) + XLEN'(4));

  assert_br_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> imem_addr_o == $past(br_target));

  assert_flush_one_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> !iv_q);

  assert_r0_alu_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wa_en_q |-> wa_addr_q != '0);

  assert_r0_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_en_q |-> wl_addr_q != '0);

  assert_load_wb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mex_ld_we |=> wl_en_q && wl_data_q == $past(dmem_rdata_i));

  assert_load_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mex_ld_we |-> dmem_re_o && !dmem_we_o);
endmodule

bind lsp_core lsp_core_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_addr_o (imem_addr_o),
  .br_taken    (br_taken),
  .br_target   (br_target),
  .iv_q        (iv_q),
  .dmem_re_o   (dmem_re_o),
  .dmem_we_o   (dmem_we_o),
  .dmem_rdata_i(dmem_rdata_i),
  .mex_ld_we   (mex_ld_we),
  .wa_en_q     (wa_en_q),
  .wa_addr_q   (wa_addr_q),
  .wl_en_q     (wl_en_q),
  .wl_addr_q   (wl_addr_q),
  .wl_data_q   (wl_data_q)
);

// File: tb/tb_lsp_core.sv
module tb_lsp_core;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 64;

  localparam logic [5:0] C_ADD = 6'h01, C_SUB = 6'h02, C_AND = 6'h03, C_OR = 6'h04,
                         C_XOR = 6'h05, C_SLT = 6'h06, C_ADDI = 6'h10, C_SLLI = 6'h11,
                         C_BEQZ = 6'h18, C_BNEZ = 6'h19, C_JMP = 6'h1A;
  localparam logic [31:0] J_SELF = {6'h1A, 26'h0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_re, dmem_we;

  logic [31:0] imem [MW];
  logic [31:0] dmem [MW];
  logic [31:0] dinit [MW];

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  lsp_core dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_re_o(dmem_re), .dmem_we_o(dmem_we),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata)
  );

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  int cyc = 0;
  always @(posedge clk) if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  task automatic check(input bit ok, input string msg);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s", msg); end
  endtask

  // program under construction
  logic [31:0] prog [MW];
  int plen;
  task automatic emit(input logic [31:0] w); prog[plen] = w; plen++; endtask

  function automatic logic [31:0] rw(input logic [5:0] op, input int s1, input int s2, input int d,
                                     input bit ls, input int ta, input int td);
    return {op, 5'(s1), 5'(s2), 5'(d), ls, 5'(ta), 5'(td)};
  endfunction
  function automatic logic [31:0] iw(input logic [5:0] op, input int s1, input int d, input int imm);
    return {op, 5'(s1), 5'(d), 16'(imm)};
  endfunction

  task automatic dump(input int n);
    for (int k = 1; k <= n; k++) emit(rw(C_ADD, 0, 0, 0, 1'b1, 0, k));
    emit(J_SELF);
  endtask

  // reference model results
  logic [31:0] e_addr [256];
  logic [31:0] e_data [256];
  int          e_cyc  [256];
  int nexp, nld_exp, last_cyc;

  task automatic model();
    logic [31:0] rg [32];
    logic [31:0] m [MW];
    logic [31:0] pc, w, a, b, res, ldv;
    logic [5:0]  op;
    int slot;
    bit ldw;
    for (int i = 0; i < 32; i++) rg[i] = '0;
    for (int i = 0; i < MW; i++) m[i] = dinit[i];
    pc = 0; slot = 0; nexp = 0; nld_exp = 0;
    for (int step = 0; step < 4000; step++) begin
      w = imem[pc[7:2]];
      if (w == J_SELF) break;
      op = w[31:26];
      if (op >= C_ADD && op <= C_SLT) begin
        a = rg[w[25:21]]; b = rg[w[20:16]];
        case (op)
          C_ADD: res = a + b;
          C_SUB: res = a - b;
          C_AND: res = a & b;
          C_OR:  res = a | b;
          C_XOR: res = a ^ b;
          default: res = {31'b0, $signed(a) < $signed(b)};
        endcase
        ldw = 1'b0; ldv = '0;
        if (w[9:5] != 0 || w[4:0] != 0) begin
          if (w[10]) begin
            e_addr[nexp] = rg[w[9:5]]; e_data[nexp] = rg[w[4:0]]; e_cyc[nexp] = slot + 2; nexp++;
            m[rg[w[9:5]][7:2]] = rg[w[4:0]];
          end else begin
            nld_exp++; ldv = m[rg[w[9:5]][7:2]]; ldw = 1'b1;
          end
        end
        if (w[15:11] != 0) rg[w[15:11]] = res;
        if (ldw && w[4:0] != 0) rg[w[4:0]] = ldv;
      end else if (op == C_ADDI || op == C_SLLI) begin
        a = rg[w[25:21]];
        res = (op == C_ADDI) ? a + {{16{w[15]}}, w[15:0]} : a << w[4:0];
        if (w[20:16] != 0) rg[w[20:16]] = res;
      end else if (op == C_BEQZ || op == C_BNEZ) begin
        a = rg[w[25:21]];
        if ((op == C_BEQZ) == (a == 0)) begin
          pc = pc + {{16{w[15]}}, w[15:0]}; slot += 2; continue;
        end
      end else if (op == C_JMP) begin
        pc = pc + {{6{w[25]}}, w[25:0]}; slot += 2; continue;
      end
      pc += 4; slot += 1;
    end
    last_cyc = slot + 2;
  endtask

  // port monitor
  bit mon_on = 1'b0;
  int sidx, nld;
  string cur_tag;
  always @(negedge clk) if (mon_on) begin
    if (dmem_we) begin
      if (sidx < nexp)
        check(dmem_addr == e_addr[sidx] && dmem_wdata == e_data[sidx] && cyc == e_cyc[sidx],
              $sformatf("%s store %0d: got addr=%h data=%h cyc=%0d, expected addr=%h data=%h cyc=%0d",
                        cur_tag, sidx, dmem_addr, dmem_wdata, cyc, e_addr[sidx], e_data[sidx], e_cyc[sidx]));
      else
        check(1'b0, $sformatf("%s extra store: got addr=%h data=%h, expected none", cur_tag, dmem_addr, dmem_wdata));
      sidx++;
    end
    if (dmem_re) nld++;
  end

  task automatic run_prog(input string tag);
    for (int i = 0; i < MW; i++) imem[i] = (i < plen) ? prog[i] : J_SELF;
    for (int i = 0; i < MW; i++) dmem[i] = dinit[i];
    model();
    cur_tag = tag;
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check(imem_addr == 0 && !dmem_we && !dmem_re,
          $sformatf("R1 reset: got iaddr=%h we=%b re=%b, expected 0 0 0", imem_addr, dmem_we, dmem_re));
    sidx = 0; nld = 0; mon_on = 1'b1;
    @(negedge clk); rst_ni = 1'b1;
    check(imem_addr == 0, $sformatf("R1 first fetch: got %h, expected 0", imem_addr));
    while (cyc < last_cyc + 8) @(negedge clk);
    mon_on = 1'b0;
    check(sidx == nexp, $sformatf("%s store count: got %0d, expected %0d", tag, sidx, nexp));
    check(nld == nld_exp, $sformatf("%s load count: got %0d, expected %0d", tag, nld, nld_exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got no completion, expected end of run");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MW; i++) dinit[i] = 32'h1357_0000 ^ (i * 32'h0101_0107);

    // ALU, immediates, r0, back-to-back dependencies
    plen = 0;
    emit(iw(C_ADDI, 0, 1, 5));
    emit(iw(C_ADDI, 0, 2, -3));
    emit(rw(C_ADD, 1, 2, 3, 0, 0, 0));
    emit(rw(C_SUB, 2, 1, 4, 0, 0, 0));
    emit(rw(C_AND, 3, 2, 5, 0, 0, 0));
    emit(rw(C_OR, 4, 1, 6, 0, 0, 0));
    emit(rw(C_XOR, 6, 5, 7, 0, 0, 0));
    emit(rw(C_SLT, 2, 1, 8, 0, 0, 0));
    emit(rw(C_SLT, 1, 2, 9, 0, 0, 0));
    emit(iw(C_SLLI, 2, 10, 4));
    emit(iw(C_ADDI, 1, 0, 7));
    emit(rw(C_ADD, 0, 1, 11, 0, 0, 0));
    dump(11);
    run_prog("R2/R3/R7/R9");

    // companion memory operations, suppression, unknown opcode
    plen = 0;
    emit(iw(C_ADDI, 0, 1, 32'h20));
    emit(iw(C_ADDI, 0, 2, 32'h55));
    emit(rw(C_ADD, 1, 2, 3, 1, 1, 2));
    emit(rw(C_ADD, 2, 2, 4, 0, 1, 4));
    emit(rw(C_XOR, 1, 1, 5, 0, 1, 0));
    emit(rw(C_ADD, 2, 2, 6, 1, 0, 0));
    emit(rw(C_ADD, 2, 0, 7, 0, 0, 0));
    emit(rw(6'h3F, 1, 2, 3, 1, 1, 2));
    emit(rw(C_SUB, 0, 0, 0, 0, 3, 1));
    emit(rw(C_ADD, 1, 0, 2, 1, 0, 1));
    dump(7);
    run_prog("R4/R5/R6/R8/R9/R12");

    // branches, jump, flush, load feeding a branch
    plen = 0;
    emit(iw(C_ADDI, 0, 1, 3));
    emit(iw(C_ADDI, 1, 1, -1));
    emit(rw(C_ADD, 0, 0, 0, 1, 0, 1));
    emit(iw(C_BNEZ, 1, 0, -8));
    emit(iw(C_BEQZ, 1, 0, 12));
    emit(iw(C_ADDI, 0, 2, 99));
    emit(rw(C_ADD, 0, 0, 0, 1, 0, 2));
    emit({C_JMP, 26'd8});
    emit(iw(C_ADDI, 0, 3, 77));
    emit(iw(C_BNEZ, 0, 0, 8));
    emit(iw(C_ADDI, 0, 4, 5));
    emit(iw(C_BEQZ, 4, 0, 8));
    emit(rw(C_ADD, 0, 0, 0, 1, 0, 4));
    emit(rw(C_ADD, 0, 0, 0, 0, 0, 5));
    emit(iw(C_BNEZ, 5, 0, 8));
    emit(iw(C_ADDI, 0, 6, 1));
    dump(6);
    run_prog("R10/R11/R13");

    // constrained random mixes
    for (int p = 0; p < 4; p++) begin
      plen = 0;
      for (int i = 0; i < 40; i++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 65) begin
          bit z;
          z = ($urandom_range(0, 4) == 0);
          emit(rw(6'($urandom_range(1, 6)), $urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                  z ? 0 : $urandom_range(0, 7), z ? 0 : $urandom_range(0, 7)));
        end else if (r < 80) begin
          emit(iw($urandom_range(0, 1) ? C_ADDI : C_SLLI, $urandom_range(0, 7),
                  $urandom_range(1, 7), $urandom_range(0, 65535)));
        end else if (r < 92 && i < 35) begin
          emit(iw($urandom_range(0, 1) ? C_BEQZ : C_BNEZ, $urandom_range(0, 7), 0,
                  $urandom_range(2, 4) * 4));
        end else begin
          emit({6'($urandom_range(32, 63)), 26'($urandom())});
        end
      end
      dump(7);
      run_prog("R12/R9/R13 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule